// File: doc/BRIEF.md
# Toggle-Flag Frozen-Word Clock Crossing

This block carries one data word at a time from a slower source clock domain into a faster target clock domain, with no FIFO. When the source accepts a send request it copies the word into a register on its own side. It then inverts a single flag bit. The word register is not allowed to change again until the target has had time to take it.

On the target side, the flag passes through a short chain of synchronising flops. The output of that chain is compared with a copy of itself that is one target clock older. When the two differ, the target loads the frozen word into a holding register, and one cycle later it raises a one-cycle valid pulse.

The source side reports busy for a fixed number of its own cycles after each accepted send. A send request that arrives while busy is dropped. That fixed window is sized so that the target's detection latency fits inside it. Traffic that produces a word on every source cycle needs a dual-clock FIFO rather than this block.

Top module: `tfx_xfer`

## Requirements
- R1: While either reset is asserted (active low), `src_busy` is 0, `dst_valid` is 0 and `dst_data` is all zeros.
- R2: A send accepted at a source clock edge (`src_send` high while `src_busy` is low) makes `src_busy` high for exactly BUSY_CYCLES source cycles, starting with the cycle after that edge.
- R3: A send request made while `src_busy` is high is ignored: its word is never delivered and it produces no `dst_valid` pulse.
- R4: The word delivered is the value `src_data` had at the accepting edge; later changes on `src_data` do not alter it.
- R5: Every accepted word appears at `dst_data` with `dst_valid` exactly once, in the order accepted.
- R6: `dst_valid` is never high on two consecutive target cycles.
- R7: `dst_data` changes only on the target cycle just before a `dst_valid` pulse, and stays constant through the pulse and between pulses.
- R8: After reset, with no send, `dst_valid` never rises.
- R9: Delivery is correct with unrelated clock periods, for any source period that is at least twice the target period plus a margin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low, asynchronous |
| src_send | input | 1 | Request to send `src_data` |
| src_data | input | DATA_W | Word to send |
| src_busy | output | 1 | High while a transfer is in flight; sends are dropped |
| dst_clk | input | 1 | Target domain clock |
| dst_rst_n | input | 1 | Target domain reset, active low, asynchronous |
| dst_data | output | DATA_W | Last captured word |
| dst_valid | output | 1 | One-cycle pulse marking a newly delivered word |

## Verification
The bench builds the block with DATA_W=16, SYNC_STAGES=2 and BUSY_CYCLES=3. It runs a 5 ns target clock against two unrelated source periods, 11 ns and 17.3 ns. Both source periods keep the busy window wider than the three-cycle detection path while letting flag edges fall at varying phases of the target clock.

With a 16-bit word, the bench can send all-ones and all-zeros corner words. It also scrambles `src_data` right after each accepted send, so any leak of the live bus into the captured word shows up as a mismatch.

// File: rtl/tfx_pkg.sv
package tfx_pkg;

    // Default geometry shared by the crossing modules.
    localparam int unsigned TFX_DATA_W_DEF      = 16;
    localparam int unsigned TFX_SYNC_STAGES_DEF = 2;
    localparam int unsigned TFX_BUSY_DEF        = 3;

    // Width needed to hold a busy count of n.
    function automatic int unsigned tfx_cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/tfx_src.sv
module tfx_src
    import tfx_pkg::*;
#(
    parameter int unsigned DATA_W      = TFX_DATA_W_DEF,
    parameter int unsigned BUSY_CYCLES = TFX_BUSY_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy_o,
    output logic              flag_o,
    output logic [DATA_W-1:0] word_o
);

    localparam int unsigned CNT_W = tfx_cnt_w(BUSY_CYCLES);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              flag;
        logic [CNT_W-1:0]  cnt;
    } src_state_t;

    src_state_t s_d, s_q;
    logic       accept_d;

    // Next-state logic: an accepted send freezes the word, flips the flag
    // and opens the busy window; otherwise the window counts down.
    always_comb begin
        s_d      = s_q;
        accept_d = send_i && (s_q.cnt == '0);
        if (accept_d) begin
            s_d.word = data_i;
            s_d.flag = ~s_q.flag;
            s_d.cnt  = CNT_W'(BUSY_CYCLES);
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = (s_q.cnt != '0);
    assign flag_o = s_q.flag;
    assign word_o = s_q.word;

    // R2: an accepted send raises busy on the following cycle.
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (send_i && !busy_o) |=> busy_o);

    // R4: the frozen word does not move while busy.
    p_word_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(word_o));

    // R3: the flag only flips on an accepted send.
    p_flag_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(send_i && !busy_o) |=> $stable(flag_o));

endmodule

// File: rtl/tfx_flag_sync.sv
module tfx_flag_sync
    import tfx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = TFX_SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_i,
    output logic change_o
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   old;
    } sync_state_t;

    sync_state_t            s_d, s_q;
    logic [SYNC_STAGES-1:0] chain_next;

    // The chain shape depends on the depth chosen.
    generate
        if (SYNC_STAGES == 1) begin : g_single
            assign chain_next = flag_i;
        end else begin : g_multi
            assign chain_next = {s_q.chain[SYNC_STAGES-2:0], flag_i};
        end
    endgenerate

    // The older copy takes the synchronised value from before the edge,
    // so it lags the synchronised flag by exactly one clock.
    always_comb begin
        s_d       = s_q;
        s_d.chain = chain_next;
        s_d.old   = s_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign change_o = s_q.chain[LAST] ^ s_q.old;

    // R5: one source flip yields one change cycle, never two in a row.
    p_single_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        change_o |=> !change_o);

endmodule

// File: rtl/tfx_dst.sv
module tfx_dst
    import tfx_pkg::*;
#(
    parameter int unsigned DATA_W = TFX_DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              change_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              cap;
        logic              vld;
    } dst_state_t;

    dst_state_t s_d, s_q;

    // Capture on the change cycle, announce one cycle later.
    always_comb begin
        s_d     = s_q;
        s_d.cap = change_i;
        s_d.vld = s_q.cap;
        if (change_i) begin
            s_d.hold = word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign data_o  = s_q.hold;
    assign valid_o = s_q.vld;

    // R6: valid is a single-cycle pulse.
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R7: the holding register moves only on a detected change.
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !change_i |=> $stable(data_o));

    // R5: each pulse traces back to a change seen two edges earlier.
    p_valid_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(change_i, 2));

endmodule

// File: rtl/tfx_xfer.sv
module tfx_xfer
    import tfx_pkg::*;
#(
    parameter int unsigned DATA_W      = TFX_DATA_W_DEF,
    parameter int unsigned SYNC_STAGES = TFX_SYNC_STAGES_DEF,
    parameter int unsigned BUSY_CYCLES = TFX_BUSY_DEF
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              src_send,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_busy,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    output logic [DATA_W-1:0] dst_data,
    output logic              dst_valid
);

    logic              flag_w;
    logic [DATA_W-1:0] word_w;
    logic              change_w;

    tfx_src #(
        .DATA_W      (DATA_W),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_src (
        .clk    (src_clk),
        .rst_n  (src_rst_n),
        .send_i (src_send),
        .data_i (src_data),
        .busy_o (src_busy),
        .flag_o (flag_w),
        .word_o (word_w)
    );

    tfx_flag_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (dst_clk),
        .rst_n    (dst_rst_n),
        .flag_i   (flag_w),
        .change_o (change_w)
    );

    // word_w crosses unsynchronised: it is frozen while the flag settles.
    tfx_dst #(
        .DATA_W (DATA_W)
    ) u_dst (
        .clk      (dst_clk),
        .rst_n    (dst_rst_n),
        .change_i (change_w),
        .word_i   (word_w),
        .data_o   (dst_data),
        .valid_o  (dst_valid)
    );

endmodule

// File: tb/tfx_xfer_bench.sv
`timescale 1ns/1ps
module tfx_xfer_bench;

    localparam int unsigned W    = 16;
    localparam int unsigned BUSY = 3;

    logic         src_clk = 1'b0;
    logic         dst_clk = 1'b0;
    logic         src_rst_n = 1'b0;
    logic         dst_rst_n = 1'b0;
    logic         src_send = 1'b0;
    logic [W-1:0] src_data = '0;
    logic         src_busy;
    logic [W-1:0] dst_data;
    logic         dst_valid;

    realtime src_half = 5.5;

    int errors = 0;
    int checks = 0;
    int sent   = 0;
    int got    = 0;
    logic [W-1:0] exp_q[$];

    always #2.5 dst_clk = ~dst_clk;
    always #(src_half) src_clk = ~src_clk;

    tfx_xfer #(.DATA_W(W), .SYNC_STAGES(2), .BUSY_CYCLES(BUSY)) u_tfx_xfer (
        .src_clk   (src_clk),
        .src_rst_n (src_rst_n),
        .src_send  (src_send),
        .src_data  (src_data),
        .src_busy  (src_busy),
        .dst_clk   (dst_clk),
        .dst_rst_n (dst_rst_n),
        .dst_data  (dst_data),
        .dst_valid (dst_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: wait for idle, present a word for one edge, then scramble the bus.
    task automatic send_word(input logic [W-1:0] v);
        @(negedge src_clk);
        while (src_busy) @(negedge src_clk);
        src_send = 1'b1;
        src_data = v;
        exp_q.push_back(v);
        sent++;
        @(negedge src_clk);
        src_send = 1'b0;
        src_data = ~v;  // R4: later bus values must not leak into the word
    endtask

    // Monitor / scoreboard in the target domain.
    initial begin : monitor
        logic [W-1:0] prev_data = '0;
        bit           prev_valid = 1'b0;
        bit           moved = 1'b0;
        forever begin
            @(negedge dst_clk);
            if (dst_rst_n) begin
                if (moved) begin
                    // R7: data moved on the previous cycle, so valid must follow now
                    check(dst_valid, "R7", dst_valid, 1);
                end
                if (dst_valid) begin
                    // R6: no back-to-back valid cycles
                    check(!prev_valid, "R6", prev_valid, 0);
                    // R7: data holds through the pulse
                    check(dst_data == prev_data || moved, "R7", dst_data, prev_data);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R3", dst_data, 0);  // unexpected word
                    end else begin
                        logic [W-1:0] e;
                        e = exp_q.pop_front();
                        check(dst_data == e, "R5", dst_data, e);
                    end
                    got++;
                end
                moved      = (dst_data != prev_data) && !dst_valid;
                prev_data  = dst_data;
                prev_valid = dst_valid;
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge dst_clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int n;
        // R1: reset values
        repeat (3) @(negedge dst_clk);
        check(src_busy == 1'b0, "R1", src_busy, 0);
        check(dst_valid == 1'b0, "R1", dst_valid, 0);
        check(dst_data == '0, "R1", dst_data, 0);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;

        // R8: idle after reset, nothing arrives
        repeat (40) @(negedge dst_clk);
        check(got == 0, "R8", got, 0);
        check(src_busy == 1'b0, "R8", src_busy, 0);

        // R2: busy window length
        send_word(16'hA5A5);
        n = 0;
        while (src_busy) begin
            n++;
            @(negedge src_clk);
        end
        check(n == BUSY, "R2", n, BUSY);

        // R3: request during busy is dropped
        @(negedge src_clk);
        src_send = 1'b1;
        src_data = 16'h1234;
        exp_q.push_back(16'h1234);
        sent++;
        @(negedge src_clk);
        src_send = 1'b0;
        check(src_busy == 1'b1, "R2", src_busy, 1);
        src_send = 1'b1;
        src_data = 16'hDEAD;  // arrives while busy: not queued
        @(negedge src_clk);
        src_send = 1'b0;
        src_data = '0;

        // R9: phase A, 11 ns source clock, numbered stream
        for (int i = 1; i <= 20; i++) send_word(W'(i * 16'h0101 + i));
        send_word('1);
        send_word('0);

        // R9: phase B, 17.3 ns source clock
        src_half = 8.65;
        for (int i = 21; i <= 40; i++) send_word(W'(i * 16'h0311));
        send_word(16'h8001);

        // Drain and check completeness
        n = 0;
        while (exp_q.size() != 0 && n < 400) begin
            @(negedge dst_clk);
            n++;
        end
        repeat (20) @(negedge dst_clk);
        check(exp_q.size() == 0, "R5", exp_q.size(), 0);
        check(got == sent, "R3", got, sent);
        check(dst_valid == 1'b0, "R6", dst_valid, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule